// File: doc/BRIEF.md
# Condition Flag Register with Branch Resolver

This block holds the processor's eight condition flags and decides the outcome of conditional branches. Reading from the most significant bit down, the flags are: interrupt enable (I), transfer bit (T), half carry (H), signed result (S), overflow (V), negative (N), zero (Z) and carry (C). The ALU writes any subset of them through a per-bit mask. A bit-indexed command sets or clears a single flag, and this one path serves every individual set-flag and clear-flag operation. A transfer port copies one bit of a register byte into T, and it can also merge T back into a chosen bit of a byte without touching any flag. An interrupt-return strobe sets I, and the I bit is sent out to the interrupt logic.

For a conditional branch, the decoder supplies a flag index, a polarity and a 7-bit signed offset. The resolver tests the selected flag against the polarity. A taken branch produces PC + offset + 1; a branch that is not taken produces PC + 1. A taken/not-taken indication and the instruction's cycle count (1 or 2) go back to the sequencer. Signed comparisons test the dedicated S flag (bit 4) and unsigned comparisons test C (bit 0).

Top module: `cond_flag_unit`

## Requirements
- R1: After a synchronous active-low reset, all eight flags read 0 and `irq_enable` is 0. The flag layout is fixed: bit 7 I, bit 6 T, bit 5 H, bit 4 S, bit 3 V, bit 2 N, bit 1 Z, bit 0 C, and `irq_enable` always equals bit 7.
- R2: When `alu_we` is 1, every flag whose `alu_mask` bit is 1 takes the matching `alu_flags` bit at the next clock edge. Flags whose mask bit is 0 keep their value.
- R3: When `cmd_en` is 1, flag `cmd_idx` becomes `cmd_set` (1 = set, 0 = clear) at the next edge. No other flag changes.
- R4: If a set/clear command and another source (ALU write, T store or interrupt return) target the same flag in one cycle, the command's value wins for that flag. The other source still updates its remaining flags.
- R5: When `tstore_en` is 1, T (bit 6) takes `xfer_src[xfer_sel]` at the next edge.
- R6: `xfer_merged` equals `xfer_src` with bit `xfer_sel` replaced by the current T. Producing it changes no flag.
- R7: When `iret_en` is 1, I (bit 7) becomes 1 at the next edge.
- R8: With `br_en` at 1, the branch is taken exactly when flag `br_idx` equals `br_on_set`. Then `pc_next` = `pc_cur` + sign-extended `br_off` + 1. Otherwise, including when `br_en` is 0, `pc_next` = `pc_cur` + 1 and `br_taken` is 0.
- R9: `br_off` is a 7-bit two's-complement value, so 7'h40 means -64. The sum wraps modulo 2^PC_W.
- R10: `br_cycles` is 2 for a taken branch and 1 otherwise.
- R11: The signed comparisons test S: greater-or-equal is index 4 with polarity 0, and less-than is index 4 with polarity 1. The unsigned comparisons test C: same-or-higher is index 0 with polarity 0, and lower is index 0 with polarity 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alu_we | input | 1 | ALU flag write strobe |
| alu_mask | input | 8 | Flags the ALU writes |
| alu_flags | input | 8 | Flag values from the ALU |
| cmd_en | input | 1 | Single-flag command strobe |
| cmd_set | input | 1 | 1 sets, 0 clears the indexed flag |
| cmd_idx | input | 3 | Flag index of the command |
| tstore_en | input | 1 | Copy a source bit into T |
| xfer_src | input | 8 | Register byte for T store and T merge |
| xfer_sel | input | 3 | Bit position within `xfer_src` |
| xfer_merged | output | 8 | `xfer_src` with the selected bit replaced by T |
| iret_en | input | 1 | Interrupt return, sets I |
| br_en | input | 1 | Conditional branch being resolved |
| br_idx | input | 3 | Flag index tested |
| br_on_set | input | 1 | Polarity that takes the branch |
| br_off | input | 7 | Signed branch offset |
| pc_cur | input | 16 | Current program counter |
| pc_next | output | 16 | Next program counter |
| br_taken | output | 1 | Branch taken |
| br_cycles | output | 2 | Cycle count of the branch |
| flags | output | 8 | Flag register |
| irq_enable | output | 1 | I flag for interrupt logic |

## Verification
An ALU flag write and a single-flag set/clear command can land in the same cycle. The same is true of a T store or an interrupt return together with a command aimed at T or I. The bench drives each such pair in one cycle, with the command opposing the other source on the shared flag. One cycle later it checks that the command's value holds on that flag while the other source's remaining bits still land. Branches are judged combinationally against flag states that were built up in earlier cycles, including negative offsets and PC wrap.

// File: rtl/cfu_pkg.sv
// Shared constants for the condition flag unit: flag positions and widths.
package cfu_pkg;
    localparam int FLAG_W = 8;
    localparam int IDX_W  = $clog2(FLAG_W);
    localparam int F_C = 0;
    localparam int F_Z = 1;
    localparam int F_N = 2;
    localparam int F_V = 3;
    localparam int F_S = 4;
    localparam int F_H = 5;
    localparam int F_T = 6;
    localparam int F_I = 7;
    typedef logic [FLAG_W-1:0] flags_t;
    typedef logic [IDX_W-1:0]  fidx_t;
endpackage

// File: rtl/cfu_flag_store.sv
// Flag register with per-bit next-state selection.
// Assumes: at most one command per cycle; source priority per bit (low to
// high) is hold, ALU write, T store / interrupt return, set/clear command.
module cfu_flag_store
    import cfu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   alu_we,
    input  flags_t alu_mask,
    input  flags_t alu_flags,
    input  logic   cmd_en,
    input  logic   cmd_set,
    input  fidx_t  cmd_idx,
    input  logic   t_wr_en,
    input  logic   t_wr_val,
    input  logic   i_set_en,
    output flags_t flags_q
);
    flags_t flags_d;

    for (genvar g = 0; g < FLAG_W; g++) begin : g_bit
        // Next value of flag g by priority.
        always_comb begin
            flags_d[g] = flags_q[g];
            if (alu_we && alu_mask[g]) flags_d[g] = alu_flags[g];
            if (g == F_T) begin
                if (t_wr_en) flags_d[g] = t_wr_val;
            end
            if (g == F_I) begin
                if (i_set_en) flags_d[g] = 1'b1;
            end
            if (cmd_en && (cmd_idx == fidx_t'(g))) flags_d[g] = cmd_set;
        end
    end

    // Register the flags; reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assert_cmd_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_en |=> flags_q[$past(cmd_idx)] == $past(cmd_set));

    assert_cmd_others_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_en && !alu_we && !t_wr_en && !i_set_en) |=>
        ((flags_q ^ $past(flags_q)) & ~(flags_t'(1) << $past(cmd_idx))) == '0);

    assert_alu_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_we && !cmd_en && !t_wr_en && !i_set_en) |=>
        (((flags_q ^ $past(alu_flags)) & $past(alu_mask)) == '0) &&
        (((flags_q ^ $past(flags_q)) & ~$past(alu_mask)) == '0));

    assert_iret_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (i_set_en && !(cmd_en && cmd_idx == fidx_t'(F_I))) |=> flags_q[F_I]);

    assert_cmd_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_en && alu_we && alu_mask[cmd_idx]) |=>
        flags_q[$past(cmd_idx)] == $past(cmd_set));
endmodule

// File: rtl/cfu_bit_xfer.sv
// Bit transfer between a register byte and T: selects one bit for a T
// store and merges T into one bit position. Purely combinational.
module cfu_bit_xfer
    import cfu_pkg::*;
(
    input  flags_t src,
    input  fidx_t  sel,
    input  logic   t_bit,
    output logic   picked,
    output flags_t merged
);
    // Pick the selected source bit.
    always_comb picked = src[sel];

    for (genvar g = 0; g < FLAG_W; g++) begin : g_merge
        // Replace the selected position with T.
        always_comb merged[g] = (sel == fidx_t'(g)) ? t_bit : src[g];
    end
endmodule

// File: rtl/cfu_branch_eval.sv
// Branch resolver: tests one flag against a polarity and forms the next PC.
// Assumes PC_W > OFF_W; arithmetic wraps modulo 2^PC_W.
module cfu_branch_eval
    import cfu_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int OFF_W = 7
) (
    input  logic             en,
    input  flags_t           flags,
    input  fidx_t            idx,
    input  logic             on_set,
    input  logic [OFF_W-1:0] off,
    input  logic [PC_W-1:0]  pc,
    output logic             taken,
    output logic [PC_W-1:0]  pc_next,
    output logic [1:0]       cycles
);
    localparam int EXT_W = PC_W - OFF_W;
    logic [PC_W-1:0] off_ext;
    logic [PC_W-1:0] seq_pc;

    // Condition test and sign extension of the offset.
    always_comb begin
        taken   = en && (flags[idx] == on_set);
        off_ext = {{EXT_W{off[OFF_W-1]}}, off};
        seq_pc  = pc + PC_W'(1);
    end

    // Target selection and cycle count.
    always_comb begin
        pc_next = taken ? (seq_pc + off_ext) : seq_pc;
        cycles  = taken ? 2'd2 : 2'd1;
    end
endmodule

// File: rtl/cond_flag_unit.sv
// Top: condition flag register, T transfer and branch resolver.
// Assumes the decoder asserts at most one flag command per cycle; branch
// decisions use the registered flags of the current cycle.
module cond_flag_unit
    import cfu_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int OFF_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alu_we,
    input  logic [7:0]       alu_mask,
    input  logic [7:0]       alu_flags,
    input  logic             cmd_en,
    input  logic             cmd_set,
    input  logic [2:0]       cmd_idx,
    input  logic             tstore_en,
    input  logic [7:0]       xfer_src,
    input  logic [2:0]       xfer_sel,
    output logic [7:0]       xfer_merged,
    input  logic             iret_en,
    input  logic             br_en,
    input  logic [2:0]       br_idx,
    input  logic             br_on_set,
    input  logic [OFF_W-1:0] br_off,
    input  logic [PC_W-1:0]  pc_cur,
    output logic [PC_W-1:0]  pc_next,
    output logic             br_taken,
    output logic [1:0]       br_cycles,
    output logic [7:0]       flags,
    output logic             irq_enable
);
    flags_t flags_q;
    logic   t_pick;

    cfu_bit_xfer u_xfer (
        .src    (xfer_src),
        .sel    (xfer_sel),
        .t_bit  (flags_q[F_T]),
        .picked (t_pick),
        .merged (xfer_merged)
    );

    cfu_flag_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .alu_we    (alu_we),
        .alu_mask  (alu_mask),
        .alu_flags (alu_flags),
        .cmd_en    (cmd_en),
        .cmd_set   (cmd_set),
        .cmd_idx   (cmd_idx),
        .t_wr_en   (tstore_en),
        .t_wr_val  (t_pick),
        .i_set_en  (iret_en),
        .flags_q   (flags_q)
    );

    cfu_branch_eval #(.PC_W(PC_W), .OFF_W(OFF_W)) u_branch (
        .en      (br_en),
        .flags   (flags_q),
        .idx     (br_idx),
        .on_set  (br_on_set),
        .off     (br_off),
        .pc      (pc_cur),
        .taken   (br_taken),
        .pc_next (pc_next),
        .cycles  (br_cycles)
    );

    // Drive the flag outputs.
    always_comb begin
        flags      = flags_q;
        irq_enable = flags_q[F_I];
    end

    assert_tstore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tstore_en && !(cmd_en && cmd_idx == 3'(F_T))) |=>
        flags[F_T] == $past(xfer_src[xfer_sel]));

    assert_merge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_merged[xfer_sel] == flags[F_T]);

    assert_idle_branch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !br_en |-> (!br_taken && pc_next == pc_cur + PC_W'(1)));

    assert_cycles_R10: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> br_cycles == 2'd2);
endmodule

// File: tb/test_cond_flag_unit.sv
module test_cond_flag_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        alu_we, cmd_en, cmd_set, tstore_en, iret_en, br_en, br_on_set;
    logic [7:0]  alu_mask, alu_flags, xfer_src, xfer_merged, flags;
    logic [2:0]  cmd_idx, xfer_sel, br_idx;
    logic [6:0]  br_off;
    logic [15:0] pc_cur, pc_next;
    logic        br_taken, irq_enable;
    logic [1:0]  br_cycles;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cond_flag_unit i_cond_flag_unit (
        .clk(clk), .rst_n(rst_n), .alu_we(alu_we), .alu_mask(alu_mask),
        .alu_flags(alu_flags), .cmd_en(cmd_en), .cmd_set(cmd_set),
        .cmd_idx(cmd_idx), .tstore_en(tstore_en), .xfer_src(xfer_src),
        .xfer_sel(xfer_sel), .xfer_merged(xfer_merged), .iret_en(iret_en),
        .br_en(br_en), .br_idx(br_idx), .br_on_set(br_on_set),
        .br_off(br_off), .pc_cur(pc_cur), .pc_next(pc_next),
        .br_taken(br_taken), .br_cycles(br_cycles), .flags(flags),
        .irq_enable(irq_enable)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        alu_we = 0; alu_mask = 0; alu_flags = 0; cmd_en = 0; cmd_set = 0;
        cmd_idx = 0; tstore_en = 0; xfer_src = 0; xfer_sel = 0; iret_en = 0;
        br_en = 0; br_idx = 0; br_on_set = 0; br_off = 0; pc_cur = 0;
    endtask

    // Apply the currently set strobes for one edge, then check the flags.
    task automatic step(input string req, input logic [7:0] exp);
        @(negedge clk);
        idle();
        #1 chk(req, {8'h00, flags}, {8'h00, exp});
    endtask

    task automatic alu_set(input logic [7:0] m, input logic [7:0] v, input logic [7:0] exp, input string req);
        @(negedge clk); idle(); alu_we = 1; alu_mask = m; alu_flags = v;
        step(req, exp);
    endtask

    task automatic cmd(input logic s, input logic [2:0] i, input logic [7:0] exp);
        @(negedge clk); idle(); cmd_en = 1; cmd_set = s; cmd_idx = i;
        step("R3 set/clear", exp);
    endtask

    task automatic t_reset();
        idle(); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1; #1;
        chk("R1 reset flags", {8'h00, flags}, 16'h0000);
        chk("R1 reset irq_enable", {15'h0, irq_enable}, 16'h0000);
    endtask

    task automatic t_alu();
        alu_set(8'hF0, 8'hA5, 8'hA0, "R2 alu upper");
        alu_set(8'h0F, 8'h3C, 8'hAC, "R2 alu lower");
        chk("R1 irq_enable follows bit7", {15'h0, irq_enable}, 16'h0001);
    endtask

    task automatic t_setclr();
        cmd(1, 3'd1, 8'hAE);
        cmd(0, 3'd7, 8'h2E);
        cmd(0, 3'd5, 8'h0E);
    endtask

    task automatic t_collide();
        @(negedge clk); idle(); alu_we = 1; alu_mask = 8'hFF; alu_flags = 8'h00;
        cmd_en = 1; cmd_set = 1; cmd_idx = 3'd3;
        step("R4 set beats alu", 8'h08);
        @(negedge clk); idle(); alu_we = 1; alu_mask = 8'hFF; alu_flags = 8'hFF;
        cmd_en = 1; cmd_set = 0; cmd_idx = 3'd0;
        step("R4 clear beats alu", 8'hFE);
    endtask

    task automatic t_tstore();
        @(negedge clk); idle(); tstore_en = 1; xfer_src = 8'hBF; xfer_sel = 3'd6;
        step("R5 store 0", 8'hBE);
        @(negedge clk); idle(); tstore_en = 1; xfer_src = 8'h04; xfer_sel = 3'd2;
        step("R5 store 1", 8'hFE);
        @(negedge clk); idle(); tstore_en = 1; xfer_src = 8'hFF; xfer_sel = 3'd0;
        cmd_en = 1; cmd_set = 0; cmd_idx = 3'd6;
        step("R4 clear beats T store", 8'hBE);
    endtask

    task automatic t_tload();
        @(negedge clk); idle(); xfer_src = 8'hFF; xfer_sel = 3'd2;
        #1 chk("R6 merge T=0", {8'h00, xfer_merged}, 16'h00FB);
        step("R6 flags unchanged", 8'hBE);
        cmd(1, 3'd6, 8'hFE);
        @(negedge clk); idle(); xfer_src = 8'h00; xfer_sel = 3'd5;
        #1 chk("R6 merge T=1", {8'h00, xfer_merged}, 16'h0020);
        step("R6 flags unchanged", 8'hFE);
    endtask

    task automatic t_iret();
        cmd(0, 3'd7, 8'h7E);
        @(negedge clk); idle(); iret_en = 1;
        step("R7 iret sets I", 8'hFE);
        @(negedge clk); idle(); iret_en = 1; cmd_en = 1; cmd_set = 0; cmd_idx = 3'd7;
        step("R4 clear beats iret", 8'h7E);
    endtask

    task automatic br(input string req, input logic e, input logic [2:0] i, input logic s,
                      input logic [6:0] k, input logic [15:0] pc,
                      input logic [15:0] exp_pc, input logic exp_tk);
        @(negedge clk); idle();
        br_en = e; br_idx = i; br_on_set = s; br_off = k; pc_cur = pc;
        #1;
        chk(req, pc_next, exp_pc);
        chk({req, " taken"}, {15'h0, br_taken}, {15'h0, exp_tk});
        chk({"R10 cycles ", req}, {14'h0, br_cycles}, exp_tk ? 16'd2 : 16'd1);
    endtask

    task automatic t_branch();
        alu_set(8'hFF, 8'h01, 8'h01, "R2 load C");
        br("R8 taken fwd", 1, 3'd0, 1, 7'd5, 16'h0100, 16'h0106, 1);
        br("R8 not taken", 1, 3'd0, 0, 7'd5, 16'h0100, 16'h0101, 0);
        br("R9 negative offset", 1, 3'd0, 1, 7'h40, 16'h0100, 16'h00C1, 1);
        br("R9 wrap down", 1, 3'd0, 1, 7'h7F, 16'h0000, 16'h0000, 1);
        br("R9 wrap up", 1, 3'd0, 1, 7'h00, 16'hFFFF, 16'h0000, 1);
        br("R8 disabled", 0, 3'd0, 1, 7'd5, 16'h0100, 16'h0101, 0);
        br("R11 lower", 1, 3'd0, 1, 7'd3, 16'h0200, 16'h0204, 1);
        br("R11 same-or-higher", 1, 3'd0, 0, 7'd3, 16'h0200, 16'h0201, 0);
    endtask

    task automatic t_signed();
        alu_set(8'hFF, 8'h10, 8'h10, "R2 load S");
        br("R11 less-than S=1", 1, 3'd4, 1, 7'd2, 16'h0010, 16'h0013, 1);
        br("R11 ge S=1", 1, 3'd4, 0, 7'd2, 16'h0010, 16'h0011, 0);
        br("R11 same-or-higher C=0", 1, 3'd0, 0, 7'd2, 16'h0010, 16'h0013, 1);
        alu_set(8'hFF, 8'h0C, 8'h0C, "R2 N,V set S clear");
        br("R11 ge uses S not N^V", 1, 3'd4, 0, 7'd2, 16'h0010, 16'h0013, 1);
        br("R11 lt S=0", 1, 3'd4, 1, 7'd2, 16'h0010, 16'h0011, 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        t_reset();
        t_alu();
        t_setclr();
        t_collide();
        t_tstore();
        t_tload();
        t_iret();
        t_branch();
        t_signed();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end
endmodule